// File: doc/BRIEF.md
# Periodic Battery Fault Supervisor

This block runs the once-per-second health check of a battery pack. A free-running one-second tick starts a cycle: the block pulses a sample request and then takes in a framed byte stream on a simple valid/data handshake. The frame holds every cell voltage and every pack temperature as a 16-bit word, followed by a 16-bit CRC. The block compares each word against programmable upper and lower limits as it arrives. The comparison result is committed only after the frame's CRC matches.

A limit violation in a CRC-good frame sets sticky per-category fault flags and latches a contactor-open command. A frame with a bad CRC is dropped, and a CRC-error counter records it. A CRC-good frame with no violation, arriving while no fault is latched, produces a one-cycle strobe that tells the balancing logic downstream that fresh, trusted measurements exist. The latched fault state is released only by a clear pulse, and only after the most recent trusted frame has come back clean.

Top module: `batt_fault_sup`

## Requirements
- R1: A tick while no cycle is in progress starts a cycle. One clock after that tick, req_o is high for exactly one cycle.
- R2: The frame is NUM_CELLS cell words, then NUM_TEMPS temperature words, then the CRC. Each item is two bytes, high byte first. Bytes that arrive while no cycle is in progress are ignored.
- R3: The CRC is CRC-16 with polynomial 0x8005, initial value 0, no bit reflection and no final XOR, taken over the data bytes only. On a mismatch the frame is discarded: crc_err_cnt_o increments by one and the flags, contactor_open_o and meas_ready_o are left unchanged.
- R4: Cell words are unsigned millivolts. A word above cell_hi_i sets flag bit 0, and a word below cell_lo_i sets flag bit 1. A word equal to either limit is not a violation.
- R5: Temperature words are signed two's-complement tenths of a degree. A word above temp_hi_i sets flag bit 2, and a word below temp_lo_i sets flag bit 3. Equality is not a violation.
- R6: Flags are sticky and accumulate by OR. A CRC-good frame with any violation sets contactor_open_o. Both outputs update two clocks after the last frame byte is accepted.
- R7: A clear pulse resets the flags and contactor_open_o only if the most recent CRC-good frame had no violation. Otherwise the pulse is ignored.
- R8: meas_ready_o pulses for one cycle, at the same time the flags would update, only if the CRC is good, the frame is clean and no flag was latched.
- R9: A tick that arrives while a cycle is in progress is ignored and increments overrun_cnt_o. The cycle in progress completes normally.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second tick pulse |
| clr_i | input | 1 | Fault clear pulse |
| req_o | output | 1 | Sample request pulse |
| smp_valid_i | input | 1 | Sample byte valid |
| smp_data_i | input | 8 | Sample byte |
| cell_hi_i | input | 16 | Cell upper limit, mV |
| cell_lo_i | input | 16 | Cell lower limit, mV |
| temp_hi_i | input | 16 | Temperature upper limit, signed 0.1 degree |
| temp_lo_i | input | 16 | Temperature lower limit, signed 0.1 degree |
| flags_o | output | 4 | Sticky flags: cell over, cell under, temp over, temp under |
| contactor_open_o | output | 1 | Latched contactor-open command |
| meas_ready_o | output | 1 | One-cycle trusted-measurement strobe |
| crc_err_cnt_o | output | CNT_W | Count of CRC-failed frames |
| overrun_cnt_o | output | CNT_W | Count of ignored ticks |

## Verification
The bench builds the block with NUM_CELLS=3 and NUM_TEMPS=2, which gives 12-byte frames. With frames that short, many complete cycles fit in the run, and the boundary between the cell words and the temperature words falls at a word index the stimulus table reaches directly. The table covers values exactly on each limit, a negative temperature that would read as an over-limit value if compared unsigned, a frame with several violations, and a frame with a corrupted CRC. Directed tests cover the clear gating, the strobe being held off while a fault is latched, stray bytes sent while idle, and a tick that lands mid-frame.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  localparam int WORD_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int NUM_FLAGS = 4;
  localparam int F_CELL_HI = 0;
  localparam int F_CELL_LO = 1;
  localparam int F_TEMP_HI = 2;
  localparam int F_TEMP_LO = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_EVAL} bfs_state_t;

  // One byte through a non-reflected CRC-16, high bit of the byte first
  function automatic logic [WORD_W-1:0] crc16_step(input logic [WORD_W-1:0] cin,
                                                   input logic [BYTE_W-1:0] din,
                                                   input logic [WORD_W-1:0] poly);
    logic [WORD_W-1:0] r;
    logic fb;
    r = cin;
    for (int i = BYTE_W-1; i >= 0; i--) begin
      fb = r[WORD_W-1] ^ din[i];
      r  = {r[WORD_W-2:0], 1'b0};
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction
endpackage

// File: rtl/bfs_crc16.sv
module bfs_crc16 #(
  parameter logic [15:0] POLY = 16'h8005
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  always_ff @(posedge clk) begin
    if (rst || init_i) crc_o <= '0;
    else if (en_i)     crc_o <= bfs_pkg::crc16_step(crc_o, byte_i, POLY);
  end
endmodule

// File: rtl/bfs_limit_chk.sv
module bfs_limit_chk #(
  parameter int WORD_W      = 16,
  parameter bit TEMP_SIGNED = 1'b1
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              is_temp_i,
  input  logic [WORD_W-1:0] cell_hi_i,
  input  logic [WORD_W-1:0] cell_lo_i,
  input  logic [WORD_W-1:0] temp_hi_i,
  input  logic [WORD_W-1:0] temp_lo_i,
  output logic [3:0]        viol_o
);
  logic t_over, t_under;

  generate
    if (TEMP_SIGNED) begin : g_signed
      assign t_over  = $signed(word_i) > $signed(temp_hi_i);
      assign t_under = $signed(word_i) < $signed(temp_lo_i);
    end else begin : g_unsigned
      assign t_over  = word_i > temp_hi_i;
      assign t_under = word_i < temp_lo_i;
    end
  endgenerate

  always_comb begin
    viol_o = '0;
    if (is_temp_i) begin
      viol_o[bfs_pkg::F_TEMP_HI] = t_over;
      viol_o[bfs_pkg::F_TEMP_LO] = t_under;
    end else begin
      viol_o[bfs_pkg::F_CELL_HI] = word_i > cell_hi_i;
      viol_o[bfs_pkg::F_CELL_LO] = word_i < cell_lo_i;
    end
  end
endmodule

// File: rtl/batt_fault_sup.sv
module batt_fault_sup #(
  parameter int NUM_CELLS = 16,
  parameter int NUM_TEMPS = 4,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic             req_o,
  input  logic             smp_valid_i,
  input  logic [7:0]       smp_data_i,
  input  logic [15:0]      cell_hi_i,
  input  logic [15:0]      cell_lo_i,
  input  logic [15:0]      temp_hi_i,
  input  logic [15:0]      temp_lo_i,
  output logic [3:0]       flags_o,
  output logic             contactor_open_o,
  output logic             meas_ready_o,
  output logic [CNT_W-1:0] crc_err_cnt_o,
  output logic [CNT_W-1:0] overrun_cnt_o
);
  import bfs_pkg::*;

  localparam int NUM_WORDS   = NUM_CELLS + NUM_TEMPS;
  localparam int DATA_BYTES  = 2 * NUM_WORDS;
  localparam int FRAME_BYTES = DATA_BYTES + 2;
  localparam int BC_W        = $clog2(FRAME_BYTES + 1);
  localparam logic [BC_W-1:0] CRC_HI_IDX = BC_W'(DATA_BYTES);
  localparam logic [BC_W-1:0] LAST_IDX   = BC_W'(FRAME_BYTES - 1);
  localparam logic [BC_W-1:0] CELL_LIM   = BC_W'(NUM_CELLS);

  bfs_state_t            st;
  logic [BC_W-1:0]       bcnt;
  logic [7:0]            msb_q;
  logic [WORD_W-1:0]     crc_rx;
  logic [NUM_FLAGS-1:0]  pend;
  logic                  live_fault;

  logic                  byte_fire, is_data, is_temp;
  logic [WORD_W-1:0]     crc_calc;
  logic [NUM_FLAGS-1:0]  viol;

  assign byte_fire = (st == ST_RECV) && smp_valid_i;
  assign is_data   = bcnt < CRC_HI_IDX;
  assign is_temp   = (bcnt >> 1) >= CELL_LIM;

  bfs_crc16 #(.POLY(16'h8005)) crc_i (
    .clk    (clk),
    .rst    (rst),
    .init_i (st == ST_IDLE),
    .en_i   (byte_fire && is_data),
    .byte_i (smp_data_i),
    .crc_o  (crc_calc)
  );

  bfs_limit_chk #(.WORD_W(WORD_W), .TEMP_SIGNED(1'b1)) lim_i (
    .word_i    ({msb_q, smp_data_i}),
    .is_temp_i (is_temp),
    .cell_hi_i (cell_hi_i),
    .cell_lo_i (cell_lo_i),
    .temp_hi_i (temp_hi_i),
    .temp_lo_i (temp_lo_i),
    .viol_o    (viol)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st               <= ST_IDLE;
      bcnt             <= '0;
      msb_q            <= '0;
      crc_rx           <= '0;
      pend             <= '0;
      live_fault       <= 1'b0;
      req_o            <= 1'b0;
      flags_o          <= '0;
      contactor_open_o <= 1'b0;
      meas_ready_o     <= 1'b0;
      crc_err_cnt_o    <= '0;
      overrun_cnt_o    <= '0;
    end else begin
      req_o        <= 1'b0;
      meas_ready_o <= 1'b0;

      if (tick_i && st != ST_IDLE) overrun_cnt_o <= overrun_cnt_o + 1'b1;

      if (clr_i && !live_fault) begin
        flags_o          <= '0;
        contactor_open_o <= 1'b0;
      end

      case (st)
        ST_IDLE: begin
          if (tick_i) begin
            st    <= ST_RECV;
            req_o <= 1'b1;
            bcnt  <= '0;
            pend  <= '0;
          end
        end
        ST_RECV: begin
          if (byte_fire) begin
            bcnt <= bcnt + 1'b1;
            if (is_data && !bcnt[0]) msb_q <= smp_data_i;
            if (is_data && bcnt[0])  pend  <= pend | viol;
            if (bcnt == CRC_HI_IDX)  crc_rx[15:8] <= smp_data_i;
            if (bcnt == LAST_IDX) begin
              crc_rx[7:0] <= smp_data_i;
              st          <= ST_EVAL;
            end
          end
        end
        ST_EVAL: begin
          st <= ST_IDLE;
          if (crc_calc == crc_rx) begin
            live_fault <= |pend;
            if (|pend) begin
              flags_o          <= flags_o | pend;
              contactor_open_o <= 1'b1;
            end else if (flags_o == '0) begin
              meas_ready_o <= 1'b1;
            end
          end else begin
            crc_err_cnt_o <= crc_err_cnt_o + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/batt_fault_sup_chk.sv
module batt_fault_sup_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_i,
  input logic             req_o,
  input logic [3:0]       flags_o,
  input logic             contactor_open_o,
  input logic             meas_ready_o,
  input logic [CNT_W-1:0] crc_err_cnt_o,
  input logic [CNT_W-1:0] overrun_cnt_o
);
  // R1
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o);

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    meas_ready_o |=> !meas_ready_o);

  // R8
  ready_clean_chk: assert property (@(posedge clk) disable iff (rst)
    meas_ready_o |-> (flags_o == 4'b0 && !contactor_open_o));

  // R6
  flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(clr_i) |-> ((flags_o & $past(flags_o)) == $past(flags_o)));

  // R6
  contactor_match_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_o != 4'b0) == contactor_open_o);

  // R9
  overrun_step_chk: assert property (@(posedge clk) disable iff (rst)
    CNT_W'(overrun_cnt_o - $past(overrun_cnt_o)) <= CNT_W'(1));

  // R3
  crc_ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (crc_err_cnt_o != $past(crc_err_cnt_o)) |-> !meas_ready_o);
endmodule

bind batt_fault_sup batt_fault_sup_chk #(.CNT_W(CNT_W)) chk_i (
  .clk              (clk),
  .rst              (rst),
  .clr_i            (clr_i),
  .req_o            (req_o),
  .flags_o          (flags_o),
  .contactor_open_o (contactor_open_o),
  .meas_ready_o     (meas_ready_o),
  .crc_err_cnt_o    (crc_err_cnt_o),
  .overrun_cnt_o    (overrun_cnt_o)
);

// File: tb/batt_fault_sup_tb_top.sv
module batt_fault_sup_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 3;
  localparam int NT = 2;
  localparam int CW = 8;
  localparam int NDB = 2 * (NC + NT);

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, clr = 1'b0;
  logic vld = 1'b0;
  logic [7:0] dat = '0;
  logic req, copen, rdy;
  logic [3:0] flags;
  logic [CW-1:0] crc_cnt, ov_cnt;

  int n_checks = 0, n_err = 0;
  int exp_crc = 0, exp_ov = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  batt_fault_sup #(.NUM_CELLS(NC), .NUM_TEMPS(NT), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .clr_i(clr), .req_o(req),
    .smp_valid_i(vld), .smp_data_i(dat),
    .cell_hi_i(16'd3650), .cell_lo_i(16'd2500),
    .temp_hi_i(16'd450), .temp_lo_i(16'hFF9C),
    .flags_o(flags), .contactor_open_o(copen), .meas_ready_o(rdy),
    .crc_err_cnt_o(crc_cnt), .overrun_cnt_o(ov_cnt)
  );

  typedef struct packed {
    logic [16*NC-1:0] cells;
    logic [16*NT-1:0] temps;
    logic             bad;
    logic [3:0]       exp;
  } vec_t;

  // cells {c2,c1,c0}, temps {t1,t0}; limits cell 2500..3650, temp -100..450
  localparam vec_t VECS [0:7] = '{
    '{{16'd3300,16'd3300,16'd3300}, {16'd250,16'd250},   1'b0, 4'h0},
    '{{16'd3300,16'd3651,16'd3300}, {16'd250,16'd250},   1'b0, 4'h1},
    '{{16'd2499,16'd3300,16'd3300}, {16'd250,16'd250},   1'b0, 4'h2},
    '{{16'd3300,16'd3300,16'd3300}, {16'd250,16'd451},   1'b0, 4'h4},
    '{{16'd3300,16'd3300,16'd3300}, {16'hFF9B,16'd250},  1'b0, 4'h8},
    '{{16'd3650,16'd2500,16'd3300}, {16'hFF9C,16'd450},  1'b0, 4'h0},
    '{{16'd3300,16'd3700,16'd3300}, {16'd250,16'd250},   1'b1, 4'h0},
    '{{16'd2000,16'd3700,16'd3300}, {16'd500,16'd250},   1'b0, 4'h7}
  };

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, expv);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] b [NDB]);
    logic [15:0] c = 16'h0000;
    for (int k = 0; k < NDB; k++) begin
      c = c ^ {b[k], 8'h00};
      for (int j = 0; j < 8; j++)
        c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
    end
    return c;
  endfunction

  // tick, stream one frame; returns at the negedge where results are visible
  task automatic run_frame(input vec_t v, input int tick_at);
    logic [7:0] b [NDB];
    logic [15:0] c;
    for (int i = 0; i < NC; i++) begin
      b[2*i]   = v.cells[16*i+8 +: 8];
      b[2*i+1] = v.cells[16*i   +: 8];
    end
    for (int i = 0; i < NT; i++) begin
      b[2*(NC+i)]   = v.temps[16*i+8 +: 8];
      b[2*(NC+i)+1] = v.temps[16*i   +: 8];
    end
    c = ref_crc(b);
    if (v.bad) c = c ^ 16'h0001;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    for (int i = 0; i < NDB + 2; i++) begin
      @(negedge clk);
      vld  = 1'b1;
      dat  = (i < NDB) ? b[i] : ((i == NDB) ? c[15:8] : c[7:0]);
      tick = (i == tick_at);
    end
    @(negedge clk) begin vld = 1'b0; tick = 1'b0; end
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10", {req, copen, rdy, flags}, 0);
    chk("R10", {crc_cnt, ov_cnt}, 0);

    // R1 request pulse
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk("R1", req, 1);
    @(negedge clk);
    chk("R1", req, 0);
    // finish that cycle with a clean frame body (no new tick)
    begin
      logic [7:0] b [NDB];
      logic [15:0] c;
      for (int i = 0; i < NC; i++) begin b[2*i] = 8'h0C; b[2*i+1] = 8'hE4; end
      for (int i = 0; i < NT; i++) begin b[2*(NC+i)] = 8'h00; b[2*(NC+i)+1] = 8'hFA; end
      c = ref_crc(b);
      for (int i = 0; i < NDB + 2; i++) begin
        @(negedge clk); vld = 1'b1;
        dat = (i < NDB) ? b[i] : ((i == NDB) ? c[15:8] : c[7:0]);
      end
      @(negedge clk) vld = 1'b0;
      @(negedge clk);
      chk("R8", rdy, 1);
      @(negedge clk);
      chk("R8", rdy, 0);
    end

    // table walk
    for (int r = 0; r < 8; r++) begin
      run_frame(VECS[r], -1);
      if (VECS[r].bad) exp_crc++;
      chk("R3", rdy, (!VECS[r].bad && VECS[r].exp == 0) ? 1 : 0);
      chk("R4 R5", flags, VECS[r].bad ? 0 : VECS[r].exp);
      chk("R6", copen, (!VECS[r].bad && VECS[r].exp != 0) ? 1 : 0);
      chk("R3", crc_cnt, exp_crc);
      @(negedge clk);
      chk("R8", rdy, 0);
      if (!VECS[r].bad && VECS[r].exp != 0) begin
        pulse_clr();
        chk("R7", flags, VECS[r].exp);
        run_frame(VECS[0], -1);
        chk("R8", rdy, 0);
        chk("R6", flags, VECS[r].exp);
        pulse_clr();
        chk("R7", {copen, flags}, 0);
      end
    end

    // R2 stray bytes while idle are ignored
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); vld = 1'b1; dat = 8'hFF;
    end
    @(negedge clk) vld = 1'b0;
    run_frame(VECS[0], -1);
    chk("R2", rdy, 1);
    chk("R2", {crc_cnt, 4'(flags)}, {8'(exp_crc), 4'h0});

    // R9 tick mid-frame
    run_frame(VECS[0], 4);
    exp_ov++;
    chk("R9", ov_cnt, exp_ov);
    chk("R9", rdy, 1);
    @(negedge clk);
    chk("R9", req, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule